// File: doc/BRIEF.md
# Xenon Flash Strobe Controller

This block drives the strobe line of a xenon flash unit in step with the frame timing of an image sensor. When flash mode is enabled, a trigger arms the controller. The trigger is either the end of a frame's readout or the end of a frame's reset, chosen by a select input. After a programmable number of frame starts (0 to 3), the controller waits for the next vertical blanking interval. It then raises the strobe for a programmed number of clock cycles.

The strobe must never extend past blanking. If blanking ends before the programmed width has run out, the pulse is cut short. A status output reports, one cycle later, whether flash mode is enabled. Dropping the enable at any point clears the strobe and discards any pulse that is scheduled. Each trigger yields at most one pulse. Triggers that arrive while a pulse is already scheduled or running are not counted.

The controller is a five-state machine:

- **IDLE** is entered whenever the enable is low, and on reset.
- **ARMED** waits for a trigger. It is left by *trigger with no delay* (to WAIT_BLANK) or by *trigger with delay* (to COUNT, loading the frame counter).
- **COUNT** moves to WAIT_BLANK on *last frame start*, which is the frame start seen while the counter holds 1.
- **WAIT_BLANK** watches for a rising edge of blanking. It moves to PULSE on *blank start* when the width is non-zero. It returns to ARMED on *blank start, zero width*.
- **PULSE** drives the strobe high. It returns to ARMED on *width reached* or on *blank end*.
- From every state, *disable* leads to IDLE, and IDLE moves to ARMED on *enable*.

Top module: `xflash_strobe_ctrl`

## Requirements
- R1: While reset is held and after its release, strobe_o and strobe_en_o are low until the enable is sampled high.
- R2: strobe_en_o equals xenon_en_i as sampled at the previous rising clock edge, and strobe_o is never high while strobe_en_o is low.
- R3: With trig_sel_i = 0, a one-cycle pulse on readout_done_i arms a pulse, and reset_done_i is ignored.
- R4: With trig_sel_i = 1, a one-cycle pulse on reset_done_i arms a pulse, and readout_done_i is ignored.
- R5: With frame_delay_i = 0, the pulse starts at the first rising edge of vblank_i after the trigger. strobe_o goes high at the clock edge that first samples vblank_i high.
- R6: With frame_delay_i = N > 0, the controller counts N frame_start_i pulses after the trigger. Only a vblank_i rising edge after the N-th pulse starts the strobe, and earlier blanking intervals give no pulse.
- R7: When blanking lasts long enough, strobe_o stays high for exactly pulse_width_i clock cycles. A width of 0 gives no pulse.
- R8: When vblank_i falls while strobe_o is high, strobe_o goes low at the clock edge that first samples vblank_i low.
- R9: When xenon_en_i is low at a clock edge, strobe_o is low after that edge, and any scheduled or running pulse is discarded.
- R10: Each trigger yields at most one pulse. Triggers received while a pulse is scheduled or running have no effect. A new trigger after the pulse has completed arms the next one, and enabling with no trigger gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| readout_done_i | input | 1 | One-cycle pulse when a frame's readout completes |
| reset_done_i | input | 1 | One-cycle pulse when a frame's reset completes |
| vblank_i | input | 1 | High during vertical blanking |
| xenon_en_i | input | 1 | Enables flash mode |
| frame_delay_i | input | DELAY_W (2) | Number of frame starts to wait after the trigger |
| trig_sel_i | input | 1 | Trigger source: 0 = readout done, 1 = reset done |
| pulse_width_i | input | WIDTH_W (16) | Strobe width in clock cycles |
| strobe_o | output | 1 | Flash strobe |
| strobe_en_o | output | 1 | Read-only status: flash mode enabled |

## Verification
The bench builds the controller with WIDTH_W = 8 and keeps DELAY_W at its default of 2. Keeping the widths small lets the bench measure complete pulses, and pulses cut short by blanking, cycle by cycle within short blanking windows. With a 2-bit delay, every frame-delay setting in the field is available to the tests, including the counting path through several frame starts. The enable is dropped both during a pulse and while a delayed pulse is still scheduled.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_COUNT,
        ST_WAIT_BLANK,
        ST_PULSE
    } xfs_state_e;

endpackage

// File: rtl/xfs_trig_select.sv
// Chooses the arming event and detects the start of vertical blanking.
module xfs_trig_select (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic readout_done_i,
    input  logic reset_done_i,
    input  logic vblank_i,
    output logic trig_o,
    output logic blank_rise_o
);

    logic vblank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vblank_q <= 1'b0;
        end else begin
            vblank_q <= vblank_i;
        end
    end

    always_comb begin
        trig_o       = sel_i ? reset_done_i : readout_done_i;
        blank_rise_o = vblank_i && !vblank_q;
    end

endmodule

// File: rtl/xfs_frame_delay.sv
// Down counter of frame starts between the trigger and the blanking wait.
module xfs_frame_delay #(
    parameter int DELAY_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [DELAY_W-1:0] load_val_i,
    input  logic               dec_i,
    output logic               last_o
);

    localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

    logic [DELAY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last_o = (cnt_q == ONE);

endmodule

// File: rtl/xfs_pulse_timer.sv
// Counts strobe-high cycles; flags the cycle in which the width is reached.
module xfs_pulse_timer #(
    parameter int WIDTH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               run_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               reached_o
);

    localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);
    localparam logic [WIDTH_W-1:0] TOP = '1;

    logic [WIDTH_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= ONE;
        end else if (run_i && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign reached_o = (cnt_q >= width_i);

endmodule

// File: rtl/xflash_strobe_ctrl.sv
module xflash_strobe_ctrl
    import xfs_pkg::*;
#(
    parameter int WIDTH_W = 16,
    parameter int DELAY_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  logic               readout_done_i,
    input  logic               reset_done_i,
    input  logic               vblank_i,
    input  logic               xenon_en_i,
    input  logic [DELAY_W-1:0] frame_delay_i,
    input  logic               trig_sel_i,
    input  logic [WIDTH_W-1:0] pulse_width_i,
    output logic               strobe_o,
    output logic               strobe_en_o
);

    xfs_state_e state_q, state_d;
    logic       en_q;
    logic       trig, blank_rise;
    logic       fd_load, fd_dec, fd_last;
    logic       pt_clear, pt_run, pt_reached;

    xfs_trig_select u_trig (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_i          (trig_sel_i),
        .readout_done_i (readout_done_i),
        .reset_done_i   (reset_done_i),
        .vblank_i       (vblank_i),
        .trig_o         (trig),
        .blank_rise_o   (blank_rise)
    );

    xfs_frame_delay #(.DELAY_W(DELAY_W)) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (fd_load),
        .load_val_i (frame_delay_i),
        .dec_i      (fd_dec),
        .last_o     (fd_last)
    );

    xfs_pulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (pt_clear),
        .run_i     (pt_run),
        .width_i   (pulse_width_i),
        .reached_o (pt_reached)
    );

    // State register and enable status flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= xenon_en_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        fd_load  = 1'b0;
        pt_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (trig) begin
                    if (frame_delay_i == '0) begin
                        state_d = ST_WAIT_BLANK;
                    end else begin
                        state_d = ST_COUNT;
                        fd_load = 1'b1;
                    end
                end
            end
            ST_COUNT: begin
                if (frame_start_i && fd_last) begin
                    state_d = ST_WAIT_BLANK;
                end
            end
            ST_WAIT_BLANK: begin
                if (blank_rise) begin
                    if (pulse_width_i == '0) begin
                        state_d = ST_ARMED;
                    end else begin
                        state_d  = ST_PULSE;
                        pt_clear = 1'b1;
                    end
                end
            end
            ST_PULSE: begin
                if (!vblank_i || pt_reached) begin
                    state_d = ST_ARMED;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (!xenon_en_i) begin
            state_d  = ST_IDLE;
            fd_load  = 1'b0;
            pt_clear = 1'b0;
        end
    end

    // Outputs
    always_comb begin
        fd_dec      = (state_q == ST_COUNT) && frame_start_i;
        pt_run      = (state_q == ST_PULSE);
        strobe_o    = (state_q == ST_PULSE);
        strobe_en_o = en_q;
    end

endmodule

// File: rtl/xfs_strobe_checker.sv
module xfs_strobe_checker #(
    parameter int WIDTH_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vblank_i,
    input logic               xenon_en_i,
    input logic [WIDTH_W-1:0] pulse_width_i,
    input logic               strobe_o,
    input logic               strobe_en_o
);

    logic [WIDTH_W:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!strobe_o) begin
            hi_cnt <= '0;
        end else if (hi_cnt != '1) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> strobe_en_o);

    assert_blank_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> $past(vblank_i));

    assert_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (hi_cnt < {1'b0, pulse_width_i}));

    assert_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && !vblank_i) |=> !strobe_o);

    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xenon_en_i |=> !strobe_o);

endmodule

bind xflash_strobe_ctrl xfs_strobe_checker #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vblank_i      (vblank_i),
    .xenon_en_i    (xenon_en_i),
    .pulse_width_i (pulse_width_i),
    .strobe_o      (strobe_o),
    .strobe_en_o   (strobe_en_o)
);

// File: tb/xflash_strobe_ctrl_tb.sv
module xflash_strobe_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH_W    = 8;
    localparam int DELAY_W    = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_start = 1'b0;
    logic               readout_done = 1'b0;
    logic               reset_done = 1'b0;
    logic               vblank = 1'b0;
    logic               xen = 1'b0;
    logic [DELAY_W-1:0] fdelay = '0;
    logic               tsel = 1'b0;
    logic [WIDTH_W-1:0] pwidth = '0;
    logic               strobe_o;
    logic               strobe_en_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xflash_strobe_ctrl #(.WIDTH_W(WIDTH_W), .DELAY_W(DELAY_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start_i  (frame_start),
        .readout_done_i (readout_done),
        .reset_done_i   (reset_done),
        .vblank_i       (vblank),
        .xenon_en_i     (xen),
        .frame_delay_i  (fdelay),
        .trig_sel_i     (tsel),
        .pulse_width_i  (pwidth),
        .strobe_o       (strobe_o),
        .strobe_en_o    (strobe_en_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // 0 = frame start, 1 = readout done, 2 = reset done
    task automatic pulse_in(input int which);
        @(negedge clk);
        case (which)
            0: frame_start = 1'b1;
            1: readout_done = 1'b1;
            default: reset_done = 1'b1;
        endcase
        @(negedge clk);
        frame_start  = 1'b0;
        readout_done = 1'b0;
        reset_done   = 1'b0;
    endtask

    // Blanking of len cycles; counts strobe-high samples and the first one
    task automatic blank_window(input int len, output int hi, output int first);
        hi = 0;
        first = 0;
        @(negedge clk);
        vblank = 1'b1;
        for (int i = 1; i <= len + 4; i++) begin
            @(negedge clk);
            if (strobe_o) begin
                hi++;
                if (first == 0) first = i;
            end
            if (i == len) vblank = 1'b0;
        end
    endtask

    task automatic t_reset;
        idle(2);
        chk("R1 strobe in reset", strobe_o, 0);
        chk("R1 status in reset", strobe_en_o, 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 strobe after reset", strobe_o, 0);
        chk("R1 status after reset", strobe_en_o, 0);
    endtask

    task automatic t_status;
        @(negedge clk);
        xen = 1'b1;
        @(negedge clk);
        chk("R2 status follows enable", strobe_en_o, 1);
        idle(1);
    endtask

    task automatic t_no_trigger;
        int hi, first;
        pwidth = 8'd5;
        blank_window(20, hi, first);
        chk("R10 no pulse without trigger", hi, 0);
    endtask

    task automatic t_readout_delay0;
        int hi, first;
        tsel = 1'b0; fdelay = 2'd0; pwidth = 8'd5;
        pulse_in(1);
        blank_window(20, hi, first);
        chk("R3 readout trigger width", hi, 5);
        chk("R5 pulse starts at blank start", first, 1);
    endtask

    task automatic t_sel0_ignores_reset;
        int hi, first;
        tsel = 1'b0;
        pulse_in(2);
        blank_window(20, hi, first);
        chk("R3 reset_done ignored with sel 0", hi, 0);
    endtask

    task automatic t_sel1;
        int hi, first;
        tsel = 1'b1; pwidth = 8'd6;
        pulse_in(1);
        blank_window(20, hi, first);
        chk("R4 readout_done ignored with sel 1", hi, 0);
        pulse_in(2);
        blank_window(20, hi, first);
        chk("R4 reset trigger width", hi, 6);
        chk("R4 reset trigger start", first, 1);
        tsel = 1'b0;
    endtask

    task automatic t_delay(input int n);
        int hi, first;
        fdelay = n[DELAY_W-1:0]; pwidth = 8'd4;
        pulse_in(1);
        for (int k = 0; k < n; k++) begin
            blank_window(10, hi, first);
            chk($sformatf("R6 no pulse after %0d of %0d frames", k, n), hi, 0);
            pulse_in(0);
        end
        blank_window(10, hi, first);
        chk($sformatf("R6 pulse after %0d frames", n), hi, 4);
        chk("R6 delayed pulse start", first, 1);
        fdelay = 2'd0;
    endtask

    task automatic t_clip;
        int hi, first;
        pwidth = 8'd10;
        pulse_in(1);
        blank_window(4, hi, first);
        chk("R8 pulse clipped at blank end", hi, 4);
    endtask

    task automatic t_long_width;
        int hi, first;
        pwidth = 8'd200;
        pulse_in(1);
        blank_window(230, hi, first);
        chk("R7 long width exact", hi, 200);
    endtask

    task automatic t_width0;
        int hi, first;
        pwidth = 8'd0;
        pulse_in(1);
        blank_window(10, hi, first);
        chk("R7 zero width no pulse", hi, 0);
        pwidth = 8'd3;
        blank_window(10, hi, first);
        chk("R7 zero width consumed trigger", hi, 0);
    endtask

    task automatic t_single;
        int hi, first;
        pwidth = 8'd3;
        pulse_in(1);
        pulse_in(1);
        blank_window(10, hi, first);
        chk("R10 double trigger one pulse", hi, 3);
        blank_window(10, hi, first);
        chk("R10 no second pulse", hi, 0);
        pulse_in(1);
        blank_window(10, hi, first);
        chk("R10 re-armed by new trigger", hi, 3);
    endtask

    task automatic t_disable_mid;
        int hi;
        pwidth = 8'd20;
        pulse_in(1);
        @(negedge clk);
        vblank = 1'b1;
        hi = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (strobe_o) hi++;
        end
        chk("R9 strobe high before disable", hi, 3);
        xen = 1'b0;
        @(negedge clk);
        chk("R9 strobe drops after disable", strobe_o, 0);
        chk("R2 status clears", strobe_en_o, 0);
        idle(3);
        vblank = 1'b0;
        xen = 1'b1;
        idle(2);
    endtask

    task automatic t_cancel_pending;
        int hi, first;
        fdelay = 2'd1; pwidth = 8'd4;
        pulse_in(1);
        @(negedge clk);
        xen = 1'b0;
        idle(2);
        xen = 1'b1;
        idle(2);
        pulse_in(0);
        blank_window(10, hi, first);
        chk("R9 pending pulse cancelled", hi, 0);
        pulse_in(1);
        pulse_in(0);
        blank_window(10, hi, first);
        chk("R9 fresh trigger after re-enable", hi, 4);
        fdelay = 2'd0;
    endtask

    initial begin
        t_reset();
        t_status();
        t_no_trigger();
        t_readout_delay0();
        t_sel0_ignores_reset();
        t_sel1();
        t_delay(1);
        t_delay(2);
        t_delay(3);
        t_clip();
        t_long_width();
        t_width0();
        t_single();
        t_disable_mid();
        t_cancel_pending();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule